// File: doc/BRIEF.md
# SDRAM Read/Write Data Mask Path

This block is the data-path control that sits between a synchronous DRAM core and its data pads. On a read it carries the word fetched by the core through a short pipeline so that it appears on the output bus a programmable number of clocks after the read command: two or three clocks. It also builds a per-byte-lane output enable. That enable follows the data-mask input with a fixed two-clock delay, so a mask sampled with one edge blanks the byte that is presented two edges later. On a write the mask acts at once. A masked lane has its write strobe held low in the same cycle, and an unmasked lane is written.

Each read carries its own latency code down the pipeline. The latency setting can therefore change between reads without disturbing a read that is already in flight. With two byte lanes, lane 0 is the low byte and lane 1 is the high byte, and each lane has its own mask bit. The memory array, the burst address counter and the pad drivers are outside the block.

Top module: `sdr_dqm_path`

## Requirements
- R1: While `rst_n` is low, and after its release until a read lands, `rd_valid`, every bit of `dq_oe` and every bit of `dq_out` are 0.
- R2: A read sampled with `cas_lat` = 0 (latency two) at edge k sets `rd_valid` and puts that cycle's `rd_word` on `dq_out` in the cycle after edge k+1, so it is captured at edge k+2.
- R3: A read sampled with `cas_lat` = 1 (latency three) at edge k sets `rd_valid` and puts that cycle's `rd_word` on `dq_out` in the cycle after edge k+2.
- R4: The latency applies to each read as it is sampled. A change of `cas_lat` does not move a read already in the pipeline.
- R5: When a latency-three read and a latency-two read issued one cycle later land in the same cycle, the older latency-three word is presented.
- R6: In a cycle with `rd_valid` high, `dq_oe[l]` is the inverse of `dqm[l]` as sampled two edges before that cycle's data is captured (mask sampled at edge j governs the output after edge j+1). `dq_oe` is 0 whenever `rd_valid` is 0.
- R7: The read mask only gates `dq_oe`. It does not change `rd_valid` or `dq_out`.
- R8: In the same cycle, `mem_we[l]` = `wr_fire` AND NOT `dqm[l]`, and `mem_wdata` equals `wr_word`.
- R9: Lane l covers data bits [8l+7:8l]. `dqm[0]` masks the low byte and `dqm[1]` masks the high byte, each independently of the other.
- R10: `dq_out` is all zeros in any cycle where `rd_valid` is 0.
- R11: Writes issued during a read burst leave the read data, its timing and its enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cas_lat | input | LAT_W | Latency code: 0 gives two clocks, 1 gives three |
| rd_fire | input | 1 | A read column access is issued this cycle |
| rd_word | input | LANE_W*LANES | Word fetched by the core for this read |
| wr_fire | input | 1 | A write column access is issued this cycle |
| wr_word | input | LANE_W*LANES | Write data from the pads |
| dqm | input | LANES | Per-lane data mask, active high |
| dq_out | output | LANE_W*LANES | Read data aligned to the latency |
| dq_oe | output | LANES | Per-lane output enable |
| rd_valid | output | 1 | Read data is present this cycle |
| mem_we | output | LANES | Per-lane write strobe to the array |
| mem_wdata | output | LANE_W*LANES | Write data to the array |

## Verification
The hardest case to reach from the ports is a latency change while reads are in flight. The bench issues a latency-three read and then a latency-two read on the next cycle, so both land together. It also issues the reverse pair, which must not collide. Mask patterns that change every cycle are laid over both latencies, so that an enable taken from the wrong mask stage, or tied to the wrong latency tap, shows up as a lane mismatch. A reset is applied while the pipeline is full, to show that in-flight reads are dropped.

// File: rtl/sdr_dqm_pkg.sv
package sdr_dqm_pkg;

    // Smallest latency the pipeline supports, in clocks.
    localparam int DEF_MIN_CL = 2;

    // Stage index at which a read with the given code becomes visible.
    function automatic int tap_of(input int min_cl, input int code);
        return min_cl - 1 + code;
    endfunction

endpackage

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe
    import sdr_dqm_pkg::*;
#(
    parameter int DW     = 16,
    parameter int LAT_W  = 1,
    parameter int MIN_CL = DEF_MIN_CL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LAT_W-1:0] push_lat,
    input  logic [DW-1:0]    push_data,
    output logic             out_vld,
    output logic [DW-1:0]    out_data
);
    localparam int NUM_CL = 2 ** LAT_W;
    localparam int DEPTH  = MIN_CL + NUM_CL - 1;

    logic [DEPTH-1:0] st_vld;
    logic [LAT_W-1:0] st_lat [DEPTH];
    logic [DW-1:0]    st_dat [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_vld[i] <= 1'b0;
                    st_lat[i] <= '0;
                    st_dat[i] <= '0;
                end else begin
                    st_vld[i] <= push;
                    st_lat[i] <= push_lat;
                    st_dat[i] <= push ? push_data : '0;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_vld[i] <= 1'b0;
                    st_lat[i] <= '0;
                    st_dat[i] <= '0;
                end else begin
                    st_vld[i] <= st_vld[i-1];
                    st_lat[i] <= st_lat[i-1];
                    st_dat[i] <= st_dat[i-1];
                end
            end
        end
    end

    // Each entry leaves at the tap matching its own code; the older entry,
    // being deeper, is examined last and so wins a collision.
    always_comb begin
        out_vld  = 1'b0;
        out_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (i >= MIN_CL - 1 && st_vld[i] &&
                tap_of(MIN_CL, int'(st_lat[i])) == i) begin
                out_vld  = 1'b1;
                out_data = st_dat[i];
            end
        end
    end

endmodule

// File: rtl/sdr_mask_dly.sv
module sdr_mask_dly #(
    parameter int LANES = 2,
    parameter int DLY   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_in,
    output logic [LANES-1:0] mask_out
);
    if (DLY == 0) begin : g_pass
        assign mask_out = mask_in;
    end else begin : g_chain
        logic [LANES-1:0] tap [DLY];
        for (genvar i = 0; i < DLY; i++) begin : g_tap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    tap[i] <= '0;
                else if (i == 0)
                    tap[i] <= mask_in;
                else
                    tap[i] <= tap[(i == 0) ? 0 : i-1];
            end
        end
        assign mask_out = tap[DLY-1];
    end

endmodule

// File: rtl/sdr_wr_gate.sv
module sdr_wr_gate #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    wr_fire,
    input  logic [LANE_W*LANES-1:0] wr_word,
    input  logic [LANES-1:0]        dqm,
    output logic [LANES-1:0]        mem_we,
    output logic [LANE_W*LANES-1:0] mem_wdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign mem_we[l]                       = wr_fire & ~dqm[l];
        assign mem_wdata[l*LANE_W +: LANE_W]   = wr_word[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/sdr_dqm_path.sv
module sdr_dqm_path
    import sdr_dqm_pkg::*;
#(
    parameter int LANE_W      = 8,
    parameter int LANES       = 2,
    parameter int LAT_W       = 1,
    parameter int MIN_CL      = DEF_MIN_CL,
    parameter int RD_MASK_DLY = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LAT_W-1:0]        cas_lat,
    input  logic                    rd_fire,
    input  logic [LANE_W*LANES-1:0] rd_word,
    input  logic                    wr_fire,
    input  logic [LANE_W*LANES-1:0] wr_word,
    input  logic [LANES-1:0]        dqm,
    output logic [LANE_W*LANES-1:0] dq_out,
    output logic [LANES-1:0]        dq_oe,
    output logic                    rd_valid,
    output logic [LANES-1:0]        mem_we,
    output logic [LANE_W*LANES-1:0] mem_wdata
);
    localparam int DW = LANE_W * LANES;

    logic [LANES-1:0] rd_mask_d;

    sdr_rd_pipe #(
        .DW     (DW),
        .LAT_W  (LAT_W),
        .MIN_CL (MIN_CL)
    ) u_rd_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_fire),
        .push_lat  (cas_lat),
        .push_data (rd_word),
        .out_vld   (rd_valid),
        .out_data  (dq_out)
    );

    sdr_mask_dly #(
        .LANES (LANES),
        .DLY   (RD_MASK_DLY)
    ) u_mask_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_in  (dqm),
        .mask_out (rd_mask_d)
    );

    sdr_wr_gate #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_wr_gate (
        .wr_fire   (wr_fire),
        .wr_word   (wr_word),
        .dqm       (dqm),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_oe
        assign dq_oe[l] = rd_valid & ~rd_mask_d[l];
    end

endmodule

// File: rtl/sdr_dqm_path_chk.sv
module sdr_dqm_path_chk #(
    parameter int LANE_W = 8,
    parameter int LANES  = 2,
    parameter int LAT_W  = 1,
    parameter int MIN_CL = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LAT_W-1:0]        cas_lat,
    input logic                    rd_fire,
    input logic [LANE_W*LANES-1:0] rd_word,
    input logic                    wr_fire,
    input logic [LANES-1:0]        dqm,
    input logic [LANE_W*LANES-1:0] dq_out,
    input logic [LANES-1:0]        dq_oe,
    input logic                    rd_valid,
    input logic [LANES-1:0]        mem_we
);
    logic [1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cyc <= '0;
        else if (cyc != 2'd3)
            cyc <= cyc + 2'd1;
    end

    // Latency checks written for the default two/three-clock range.
    if (MIN_CL == 2 && LAT_W == 1) begin : g_lat
        assert_cl2_arrive_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_fire && cas_lat == 1'b0) |=> ##1 rd_valid);

        assert_cl3_arrive_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_fire && cas_lat == 1'b1) |=> ##2 (rd_valid && dq_out == $past(rd_word, 3)));
    end

    assert_oe_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != '0) |-> rd_valid);

    assert_rd_mask_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && rd_valid) |-> (dq_oe == ~$past(dqm, 2)));

    assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (dq_out == '0));

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assert_wr_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
            dqm[l] |-> !mem_we[l]);
        assert_wr_passed_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_fire && !dqm[l]) |-> mem_we[l]);
    end

endmodule

bind sdr_dqm_path sdr_dqm_path_chk #(
    .LANE_W (LANE_W),
    .LANES  (LANES),
    .LAT_W  (LAT_W),
    .MIN_CL (MIN_CL)
) u_chk (.*);

// File: tb/test_sdr_dqm_path.sv
module test_sdr_dqm_path;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [0:0]  cas_lat = '0;
    logic        rd_fire = 1'b0;
    logic [15:0] rd_word = '0;
    logic        wr_fire = 1'b0;
    logic [15:0] wr_word = '0;
    logic [1:0]  dqm = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        rd_valid;
    logic [1:0]  mem_we;
    logic [15:0] mem_wdata;

    sdr_dqm_path i_sdr_dqm_path (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat), .rd_fire(rd_fire),
        .rd_word(rd_word), .wr_fire(wr_fire), .wr_word(wr_word), .dqm(dqm),
        .dq_out(dq_out), .dq_oe(dq_oe), .rd_valid(rd_valid),
        .mem_we(mem_we), .mem_wdata(mem_wdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nvec = 0;
    int nfail = 0;
    int e = 0;
    bit        exp_vld [MAXC];
    bit        exp_l3  [MAXC];
    bit [15:0] exp_dat [MAXC];
    bit [1:0]  mhist   [MAXC];

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s at step %0d: actual %h expected %h", tag, e, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < MAXC; i++) begin
            exp_vld[i] = 0; exp_l3[i] = 0; exp_dat[i] = '0; mhist[i] = '0;
        end
        e = 0;
    endtask

    // One clock: drive at the falling edge, check writes, then check outputs
    // registered by the following rising edge.
    task automatic step(input bit rd, input bit l3, input logic [15:0] rw,
                        input bit wr, input logic [15:0] ww, input logic [1:0] m);
        int n;
        bit [1:0] eo;
        bit [15:0] ed;
        rd_fire = rd; cas_lat = l3; rd_word = rw;
        wr_fire = wr; wr_word = ww; dqm = m;
        mhist[e] = m;
        if (rd) begin
            n = e + (l3 ? 2 : 1);
            if (l3 || !exp_l3[n]) begin   // R5: older latency-three word keeps the slot
                exp_vld[n] = 1; exp_l3[n] = l3; exp_dat[n] = rw;
            end
        end
        #1;
        chk(mem_we == (wr ? ~m : 2'b00), "R8/R9 mem_we", {14'd0, mem_we}, {14'd0, (wr ? ~m : 2'b00)});
        chk(mem_wdata == ww, "R8 mem_wdata", mem_wdata, ww);
        @(posedge clk);
        @(negedge clk);
        eo = exp_vld[e] ? ~((e >= 1) ? mhist[e-1] : 2'b00) : 2'b00;
        ed = exp_vld[e] ? exp_dat[e] : 16'h0;
        chk(rd_valid == exp_vld[e], "R2/R3/R4 rd_valid", {15'd0, rd_valid}, {15'd0, exp_vld[e]});
        chk(dq_out == ed, "R2/R3/R5/R7/R10 dq_out", dq_out, ed);
        chk(dq_oe == eo, "R6/R9 dq_oe", {14'd0, dq_oe}, {14'd0, eo});
        e++;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 16'h0, 0, 16'h0, 2'b00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rd_fire = 0; wr_fire = 0; dqm = '0; cas_lat = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R1: everything quiet while reset is held
            chk(!rd_valid && dq_oe == 2'b00 && dq_out == 16'h0, "R1 reset",
                {rd_valid, 1'b0, dq_oe, dq_out[11:0]}, 16'h0);
        end
        clear_model();
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(7));
        clear_model();
        do_reset();
        idle(3);                                         // R1 after release

        // R2: latency-two burst, no mask
        for (int i = 0; i < 4; i++) step(1, 0, 16'h1100 + 16'(i), 0, 16'h0, 2'b00);
        idle(4);
        // R3: latency-three burst, no mask
        for (int i = 0; i < 4; i++) step(1, 1, 16'h2200 + 16'(i), 0, 16'h0, 2'b00);
        idle(5);
        // R6/R7/R9: mask pattern changing each cycle on both latencies
        for (int i = 0; i < 8; i++) step(1, 0, 16'h3300 + 16'(i), 0, 16'h0, 2'(i));
        idle(4);
        for (int i = 0; i < 8; i++) step(1, 1, 16'h4400 + 16'(i), 0, 16'h0, 2'(3 - (i % 4)));
        idle(5);
        // R4/R5: latency three then two next cycle collide; reverse order does not
        step(1, 1, 16'hA3A3, 0, 16'h0, 2'b00);
        step(1, 0, 16'hB2B2, 0, 16'h0, 2'b01);
        idle(4);
        step(1, 0, 16'hC2C2, 0, 16'h0, 2'b10);
        step(1, 1, 16'hD3D3, 0, 16'h0, 2'b00);
        idle(5);
        // R8/R9: every write mask combination
        for (int i = 0; i < 4; i++) step(0, 0, 16'h0, 1, 16'h5500 + 16'(i), 2'(i));
        // R11: writes interleaved with a read burst
        for (int i = 0; i < 6; i++) step(1, i[0], 16'h6600 + 16'(i), 1, 16'h7700 + 16'(i), 2'(i));
        idle(5);
        // Mixed traffic
        for (int i = 0; i < 400; i++)
            step(1'($urandom), 1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom), 2'($urandom));
        idle(4);
        // R1: reset with reads in flight drops them
        step(1, 1, 16'hEEEE, 0, 16'h0, 2'b00);
        step(1, 0, 16'hFFFF, 0, 16'h0, 2'b00);
        do_reset();
        idle(5);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule